// File: doc/BRIEF.md
# Trap Return State Restorer

This block carries out the two trap-return operations of a processor core: the return that skips the trapped instruction (DONE) and the return that re-executes it (RETRY). When a return is issued, the block reads the saved program counter, the saved next program counter and the packed saved-state word of the current trap level. It then loads the architectural PC/NPC pair, the two condition-code nibbles, the address-space identifier, the processor-state field and the current window pointer, and lowers the trap level by one.

Every update commits on a single clock edge. In the cycle after a successful return, a one-cycle strobe asks the interrupt logic to re-evaluate pending requests. A return issued while already at trap level zero changes nothing and raises a one-cycle illegal-instruction flag instead. The trap-entry path sets the trap level through a separate load port. The saved-state storage itself sits outside the block and reaches it as plain input ports.

Top module: `trap_return_unit`

## Requirements
- R1: After reset, pc, npc, cc_x, cc_i, asi, pstate, cwp and tl are all zero, and illegal_insn and irq_recheck are low.
- R2: A return with ret_retry=0 (DONE) and tl>0 loads pc with saved_npc and npc with saved_npc+4.
- R3: A return with ret_retry=1 (RETRY) and tl>0 loads pc with saved_pc and npc with saved_npc.
- R4: A return loads cc_x from saved_state[39:36] and cc_i from saved_state[35:32].
- R5: A return loads asi from saved_state[31:24].
- R6: A return loads pstate from saved_state[19:8] ANDed with 12'hF3F, so bits 7:6 of the field always read zero.
- R7: A return takes the window field f = saved_state[7:0] and loads cwp with NWIN-1-(f mod NWIN). This holds for every 8-bit value of f, including values of NWIN and above.
- R8: Each return taken with tl>0 lowers tl by exactly one.
- R9: A return issued at tl=0 leaves every architectural output unchanged and drives illegal_insn high for the one following cycle.
- R10: irq_recheck is high for the one cycle after each successful return and low otherwise. It stays low after an illegal return.
- R11: When tl_load is high, tl takes tl_load_val on the next edge.
- R12: When tl_load and ret_valid are high in the same cycle, the load wins. The return is dropped: no register other than tl changes, and neither strobe fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ret_valid | input | 1 | Issue a trap return this cycle |
| ret_retry | input | 1 | 0 = DONE, 1 = RETRY |
| saved_pc | input | AW | Saved PC of the current trap level |
| saved_npc | input | AW | Saved NPC of the current trap level |
| saved_state | input | 40 | Packed saved state word of the current trap level |
| tl_load | input | 1 | Load trap level from the trap-entry path |
| tl_load_val | input | TLW | Trap level value to load |
| pc | output | AW | Program counter |
| npc | output | AW | Next program counter |
| cc_x | output | 4 | 64-bit condition codes |
| cc_i | output | 4 | 32-bit condition codes |
| asi | output | 8 | Address space identifier |
| pstate | output | 12 | Processor state field |
| cwp | output | CW | Current window pointer (internal order) |
| tl | output | TLW | Trap level |
| illegal_insn | output | 1 | One-cycle flag: return attempted at trap level zero |
| irq_recheck | output | 1 | One-cycle request to re-evaluate interrupts |

## Verification
Every piece of state is an output port, so a wrong field slice, a wrong window reversal or a missed modulo reduction shows on the port one cycle after the offending return. The sweep runs all 256 window-field values against a window count that is not a power of two, which exposes any error in the reduction. A trap level that decrements wrongly, or a state change made at trap level zero, shows in the same cycle that illegal_insn or irq_recheck is sampled.

// File: rtl/trap_return_unit.sv
module trap_return_unit #(
  parameter int AW   = 64,
  parameter int NWIN = 8,
  parameter int TLW  = 3,
  localparam int CW  = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ret_valid,
  input  logic           ret_retry,
  input  logic [AW-1:0]  saved_pc,
  input  logic [AW-1:0]  saved_npc,
  input  logic [39:0]    saved_state,
  input  logic           tl_load,
  input  logic [TLW-1:0] tl_load_val,
  output logic [AW-1:0]  pc,
  output logic [AW-1:0]  npc,
  output logic [3:0]     cc_x,
  output logic [3:0]     cc_i,
  output logic [7:0]     asi,
  output logic [11:0]    pstate,
  output logic [CW-1:0]  cwp,
  output logic [TLW-1:0] tl,
  output logic           illegal_insn,
  output logic           irq_recheck
);

  logic       issue, ret_ok, ret_bad;
  logic [7:0] win_fld, win_mod, win_rev;

  assign issue   = ret_valid && !tl_load;
  assign ret_ok  = issue && (tl != '0);
  assign ret_bad = issue && (tl == '0);

  assign win_fld = saved_state[7:0];
  assign win_mod = win_fld % 8'(NWIN);
  assign win_rev = 8'(NWIN - 1) - win_mod;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc <= '0; npc <= '0; cc_x <= '0; cc_i <= '0;
      asi <= '0; pstate <= '0; cwp <= '0; tl <= '0;
      illegal_insn <= 1'b0; irq_recheck <= 1'b0;
    end else begin
      illegal_insn <= ret_bad;
      irq_recheck  <= ret_ok;
      if (tl_load) tl <= tl_load_val;
      if (ret_ok) begin
        pc     <= ret_retry ? saved_pc  : saved_npc;
        npc    <= ret_retry ? saved_npc : saved_npc + AW'(4);
        cc_x   <= saved_state[39:36];
        cc_i   <= saved_state[35:32];
        asi    <= saved_state[31:24];
        pstate <= saved_state[19:8] & 12'hF3F;
        cwp    <= win_rev[CW-1:0];
        tl     <= tl - 1'b1;
      end
    end
  end

  p_tl_dec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !tl_load && tl != '0) |=> tl == $past(tl) - 1'b1);

  p_illegal_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !tl_load && tl == '0) |=> illegal_insn && $stable(pc) && $stable(tl) && $stable(cwp));

  p_recheck_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !tl_load && tl != '0) |=> irq_recheck && !illegal_insn);

  p_done_npc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !ret_retry && !tl_load && tl != '0) |=> npc == pc + AW'(4));

  p_retry_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ret_retry && !tl_load && tl != '0) |=> pc == $past(saved_pc) && npc == $past(saved_npc));

  p_load_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    tl_load |=> tl == $past(tl_load_val) && !irq_recheck && $stable(pc));

  p_cwp_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cwp) < NWIN);

endmodule

// File: tb/trap_return_unit_test.sv
module trap_return_unit_test;
  localparam int AW = 64;
  localparam int NW = 6;
  localparam int TLW = 3;
  localparam int CW = $clog2(NW);

  logic clk = 1'b0, rst_n = 1'b0;
  logic ret_valid = 1'b0, ret_retry = 1'b0, tl_load = 1'b0;
  logic [AW-1:0] saved_pc = '0, saved_npc = '0;
  logic [39:0] saved_state = '0;
  logic [TLW-1:0] tl_load_val = '0;
  logic [AW-1:0] pc, npc;
  logic [3:0] cc_x, cc_i;
  logic [7:0] asi;
  logic [11:0] pstate;
  logic [CW-1:0] cwp;
  logic [TLW-1:0] tl;
  logic illegal_insn, irq_recheck;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  trap_return_unit #(.AW(AW), .NWIN(NW), .TLW(TLW)) uut (
    .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_retry(ret_retry),
    .saved_pc(saved_pc), .saved_npc(saved_npc), .saved_state(saved_state),
    .tl_load(tl_load), .tl_load_val(tl_load_val), .pc(pc), .npc(npc),
    .cc_x(cc_x), .cc_i(cc_i), .asi(asi), .pstate(pstate), .cwp(cwp), .tl(tl),
    .illegal_insn(illegal_insn), .irq_recheck(irq_recheck));

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic set_tl(logic [TLW-1:0] v);
    @(negedge clk);
    tl_load = 1'b1; tl_load_val = v;
    @(negedge clk);
    tl_load = 1'b0;
  endtask

  task automatic issue_ret(bit retry, logic [AW-1:0] sp, logic [AW-1:0] sn, logic [39:0] st);
    ret_valid = 1'b1; ret_retry = retry;
    saved_pc = sp; saved_npc = sn; saved_state = st;
    @(negedge clk);
    ret_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 pc", pc, 0); chk("R1 npc", npc, 0); chk("R1 tl", 64'(tl), 0);
    chk("R1 cwp", 64'(cwp), 0); chk("R1 asi", 64'(asi), 0);
    chk("R1 pstate", 64'(pstate), 0); chk("R1 cc", 64'({cc_x, cc_i}), 0);
    chk("R1 strobes", 64'({illegal_insn, irq_recheck}), 0);
    rst_n = 1'b1;

    for (int f = 0; f < 256; f++) begin
      logic [7:0] ccb, asb;
      logic [11:0] psf;
      logic [TLW-1:0] t0;
      logic [AW-1:0] sp, sn;
      bit rt;
      ccb = 8'(f) ^ 8'h5A;
      asb = ~8'(f);
      psf = {4'(f * 3), 8'(f)};
      t0 = TLW'(1 + f % 7);
      sp = 64'h1000_0000_0000 + 64'(f * 16);
      sn = 64'hFFFF_FFFF_FFFF_FFF0 + 64'(f % 16);
      rt = f[0];
      set_tl(t0);
      chk("R11 tl load", 64'(tl), 64'(t0));
      issue_ret(rt, sp, sn, {ccb, asb, 4'h0, psf, 8'(f)});
      if (rt) begin
        chk("R3 pc", pc, sp); chk("R3 npc", npc, sn);
      end else begin
        chk("R2 pc", pc, sn); chk("R2 npc", npc, sn + 64'd4);
      end
      chk("R4 cc_x", 64'(cc_x), 64'(ccb[7:4]));
      chk("R4 cc_i", 64'(cc_i), 64'(ccb[3:0]));
      chk("R5 asi", 64'(asi), 64'(asb));
      chk("R6 pstate", 64'(pstate), 64'(psf & 12'hF3F));
      chk("R7 cwp", 64'(cwp), 64'(NW - 1 - (f % NW)));
      chk("R8 tl", 64'(tl), 64'(t0 - 1'b1));
      chk("R10 recheck high", 64'(irq_recheck), 1);
      chk("R9 no illegal", 64'(illegal_insn), 0);
      @(negedge clk);
      chk("R10 recheck single", 64'(irq_recheck), 0);
    end

    // R9: return at trap level 0
    set_tl('0);
    begin
      logic [AW-1:0] p0, n0; logic [CW-1:0] c0; logic [7:0] a0;
      p0 = pc; n0 = npc; c0 = cwp; a0 = asi;
      issue_ret(1'b1, 64'h55, 64'h77, 40'hFF_FF_0F_FF_03);
      chk("R9 illegal", 64'(illegal_insn), 1);
      chk("R9 pc kept", pc, p0); chk("R9 npc kept", npc, n0);
      chk("R9 cwp kept", 64'(cwp), 64'(c0)); chk("R9 asi kept", 64'(asi), 64'(a0));
      chk("R9 tl kept", 64'(tl), 0);
      chk("R10 no recheck on illegal", 64'(irq_recheck), 0);
      @(negedge clk);
      chk("R9 illegal single", 64'(illegal_insn), 0);
    end

    // R12: load and return together
    set_tl(3'd2);
    begin
      logic [AW-1:0] p0; logic [7:0] a0;
      p0 = pc; a0 = asi;
      tl_load = 1'b1; tl_load_val = 3'd5;
      issue_ret(1'b0, 64'h123, 64'h456, 40'h12_34_05_67_02);
      tl_load = 1'b0;
      chk("R12 tl loaded", 64'(tl), 5);
      chk("R12 pc kept", pc, p0); chk("R12 asi kept", 64'(asi), 64'(a0));
      chk("R12 no strobes", 64'({illegal_insn, irq_recheck}), 0);
    end

    // R8/R10: back-to-back returns
    issue_ret(1'b0, 64'h0, 64'h200, 40'h0);
    chk("R8 first", 64'(tl), 4);
    issue_ret(1'b1, 64'h300, 64'h304, 40'h0);
    chk("R8 second", 64'(tl), 3);
    chk("R3 back-to-back pc", pc, 64'h300);
    chk("R10 back-to-back", 64'(irq_recheck), 1);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog got=hung exp=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule